// File: doc/BRIEF.md
# Sensor Register Bank with Paired-Byte Access over I2C

This block is the host-facing register file of a light sensor, reached through a small I2C target. The target answers to a single 7-bit bus address, ACKs every byte it accepts, and feeds the register file with three kinds of event: a register-address byte, a data byte to write, and a request for the next byte to send. The register file keeps one 8-bit register pointer. The pointer advances after every byte moved in either direction and is not cleared by STOP, so a host can resume reading without resending an address.

Wide quantities are 16 bits and take two consecutive byte addresses, with the low byte at the even address. Two such fields are writable alarm limits. Four read-only fields carry live channel counts from the measurement logic. The block prevents torn values in both directions. A read of any low byte captures the matching high byte into one snapshot register, which the following high-byte read returns. A written low byte waits in one shadow byte and reaches a field only when a high byte is written, at which point both halves change on the same clock.

Top module: `lux_i2c_regbank`

## Requirements
- R1: Only chip address 0x39 (7 bits, then R/W bit; 0 = write) is ACKed. For any other address the target leaves SDA released for that byte and every following byte up to the next START, and no register changes.
- R2: In a write transaction, the first byte after the address sets the pointer. Each following data byte is ACKed, stored at the pointer, and then the pointer goes up by one. Map: 0x00 control (8-bit RW), 0x01 integration setting (8-bit RW), 0x02/0x03 low alarm limit low/high, 0x04/0x05 high alarm limit low/high.
- R3: The pointer keeps its value across STOP. A read that starts with the read address directly, with no register byte, begins at the pointer left by the previous transaction.
- R4: A read transaction (register byte, repeated START, address with R/W = 1) returns bytes MSB first from consecutive addresses while the host ACKs. After the host NACKs, the target releases SDA.
- R5: Reading the low byte of a 16-bit field captures its high byte. A high-byte read that follows returns the captured byte even if the live value has changed. Channel k (k = 0..3) occupies 0x20+2k (low) and 0x21+2k (high).
- R6: A low-byte write to a limit field does not change that field's output. The following high-byte write updates both halves together: going from 0x00FF to 0x0100 through separate transactions never shows 0x0000.
- R7: There is one shadow byte for all fields. A low-byte write to one limit followed by a high-byte write to the other commits {high, shadowed low} to the field whose high byte was written and leaves the first field unchanged.
- R8: Address 0x10 reads 0xDC and 0x11 reads 0x41. Writes to these addresses, and to the channel addresses, change nothing.
- R9: A byte written to an unmapped address is ACKed and discarded. A read from an unmapped address returns 0x00.
- R10: The pointer wraps from 0xFF to 0x00.
- R11: After reset all writable registers read 0, the pointer is 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| chan_i | input | NUM_CH*16 (64) | Live channel counts, channel k at bits 16k+15:16k |
| ctrl_q | output | 8 | Control register |
| itime_q | output | 8 | Integration setting register |
| thr_lo_q | output | 16 | Low alarm limit |
| thr_hi_q | output | 16 | High alarm limit |

## Verification
The bench runs the paired-byte cases step by step. It changes a channel's live count between its low-byte and high-byte reads, so a design that reads the high byte live returns the new upper byte. It writes a limit low byte in a transaction of its own and checks the output before the high byte arrives, so a design that writes straight through shows the intermediate 0x0000. It crosses one limit's low byte with the other limit's high byte, so a design with a shadow byte per field commits a stale low half. It resumes reads without a register byte and writes across 0xFF, so a pointer that clears on STOP or saturates at 0xFF lands the data at the wrong address. It sends a wrong chip address and expects NACKs with nothing changed, and it sweeps many data patterns and channel values through burst reads.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_REG, S_REG_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } i2c_state_e;

  localparam logic [7:0] A_CTRL    = 8'h00;
  localparam logic [7:0] A_ITIME   = 8'h01;
  localparam logic [7:0] A_TLO_L   = 8'h02;
  localparam logic [7:0] A_TLO_H   = 8'h03;
  localparam logic [7:0] A_THI_L   = 8'h04;
  localparam logic [7:0] A_THI_H   = 8'h05;
  localparam logic [7:0] A_ID      = 8'h10;
  localparam logic [7:0] A_REV     = 8'h11;
  localparam logic [7:0] A_CH_BASE = 8'h20;

  localparam logic [7:0] ID_VAL  = 8'hDC;
  localparam logic [7:0] REV_VAL = 8'h41;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR = 7'h39
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic       wr_en,
  output logic       rd_take,
  output logic [7:0] rx_byte
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  i2c_state_e state_q;
  logic [3:0] bitcnt_q;
  logic [7:0] shreg_q, tx_q;
  logic       rw_q, mack_q, oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (start_det) begin
      state_q  <= S_ADDR;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_det) begin
      state_q <= S_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        S_ADDR, S_REG, S_WR: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == LAST_BIT) begin
            bitcnt_q <= '0;
            if (state_q == S_ADDR) begin
              if (shreg_q[7:1] == CHIP_ADDR) begin
                oe_q    <= 1'b1;
                rw_q    <= shreg_q[0];
                state_q <= S_ADDR_ACK;
              end else begin
                state_q <= S_IDLE;
              end
            end else if (state_q == S_REG) begin
              oe_q    <= 1'b1;
              state_q <= S_REG_ACK;
            end else begin
              oe_q    <= 1'b1;
              state_q <= S_WR_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_byte;
              oe_q    <= ~rd_byte[7];
              state_q <= S_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= S_REG;
            end
          end
        end
        S_REG_ACK, S_WR_ACK: begin
          if (scl_fall) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= S_WR;
          end
        end
        S_RD: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == LAST_BIT) begin
              oe_q    <= 1'b0;
              state_q <= S_RD_ACK;
            end else begin
              tx_q <= {tx_q[6:0], 1'b0};
              oe_q <= ~tx_q[6];
            end
          end
        end
        S_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt_q <= '0;
            if (mack_q) begin
              tx_q    <= rd_byte;
              oe_q    <= ~rd_byte[7];
              state_q <= S_RD;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign sda_oe   = oe_q;
  assign rx_byte  = shreg_q;
  assign ptr_load = scl_fall && state_q == S_REG && bitcnt_q == LAST_BIT;
  assign wr_en    = scl_fall && state_q == S_WR && bitcnt_q == LAST_BIT;
  assign rd_take  = scl_fall && ((state_q == S_ADDR_ACK && rw_q) ||
                                 (state_q == S_RD_ACK && mack_q));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state_q == S_IDLE |-> !sda_oe);

  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/lux_regfile.sv
module lux_regfile
  import lux_i2c_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ptr_load,
  input  logic                   wr_en,
  input  logic                   rd_take,
  input  logic [7:0]             wdata,
  input  logic [NUM_CH*16-1:0]   chan_i,
  output logic [7:0]             rd_byte,
  output logic [7:0]             ctrl_q,
  output logic [7:0]             itime_q,
  output logic [15:0]            thr_lo_q,
  output logic [15:0]            thr_hi_q
);
  localparam int CH_W = 16;

  logic [7:0] ptr_q, shadow_q, snap_q;
  logic       snap_hit;
  logic [7:0] snap_val;

  // high byte to capture when the pointer sits on a low byte
  always_comb begin
    snap_hit = 1'b0;
    snap_val = 8'h00;
    case (ptr_q)
      A_TLO_L: begin snap_hit = 1'b1; snap_val = thr_lo_q[15:8]; end
      A_THI_L: begin snap_hit = 1'b1; snap_val = thr_hi_q[15:8]; end
      default: begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (ptr_q == 8'(A_CH_BASE + 2*k)) begin
            snap_hit = 1'b1;
            snap_val = chan_i[k*CH_W+8 +: 8];
          end
        end
      end
    endcase
  end

  always_comb begin
    rd_byte = 8'h00;
    case (ptr_q)
      A_CTRL:           rd_byte = ctrl_q;
      A_ITIME:          rd_byte = itime_q;
      A_TLO_L:          rd_byte = thr_lo_q[7:0];
      A_THI_L:          rd_byte = thr_hi_q[7:0];
      A_TLO_H, A_THI_H: rd_byte = snap_q;
      A_ID:             rd_byte = ID_VAL;
      A_REV:            rd_byte = REV_VAL;
      default: begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (ptr_q == 8'(A_CH_BASE + 2*k))
            rd_byte = chan_i[k*CH_W +: 8];
          else if (ptr_q == 8'(A_CH_BASE + 2*k + 1))
            rd_byte = snap_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      shadow_q <= '0;
      snap_q   <= '0;
      ctrl_q   <= '0;
      itime_q  <= '0;
      thr_lo_q <= '0;
      thr_hi_q <= '0;
    end else begin
      if (ptr_load)              ptr_q <= wdata;
      else if (wr_en || rd_take) ptr_q <= ptr_q + 8'd1;

      if (rd_take && snap_hit) snap_q <= snap_val;

      if (wr_en) begin
        case (ptr_q)
          A_CTRL:           ctrl_q   <= wdata;
          A_ITIME:          itime_q  <= wdata;
          A_TLO_L, A_THI_L: shadow_q <= wdata;
          A_TLO_H:          thr_lo_q <= {wdata, shadow_q};
          A_THI_H:          thr_hi_q <= {wdata, shadow_q};
          default: ;
        endcase
      end
    end
  end

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> ptr_q == $past(wdata));

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en || rd_take) && !ptr_load |=> ptr_q == 8'($past(ptr_q) + 8'd1));

  // R6
  lo_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(thr_lo_q) |-> $past(wr_en) && $past(ptr_q) == A_TLO_H);

  // R6
  hi_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(thr_hi_q) |-> $past(wr_en) && $past(ptr_q) == A_THI_H);

  // R7
  shadow_use_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) && $past(ptr_q) == A_THI_H |-> thr_hi_q[7:0] == $past(shadow_q));
endmodule

// File: rtl/lux_i2c_regbank.sv
module lux_i2c_regbank
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR   = 7'h39,
  parameter int         NUM_CH      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic [NUM_CH*16-1:0] chan_i,
  output logic [7:0]           ctrl_q,
  output logic [7:0]           itime_q,
  output logic [15:0]          thr_lo_q,
  output logic [15:0]          thr_hi_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, wr_en, rd_take;
  logic [7:0] rx_byte, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.CHIP_ADDR(CHIP_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .ptr_load(ptr_load), .wr_en(wr_en),
    .rd_take(rd_take), .rx_byte(rx_byte)
  );

  lux_regfile #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .ptr_load(ptr_load), .wr_en(wr_en),
    .rd_take(rd_take), .wdata(rx_byte), .chan_i(chan_i),
    .rd_byte(rd_byte), .ctrl_q(ctrl_q), .itime_q(itime_q),
    .thr_lo_q(thr_lo_q), .thr_hi_q(thr_hi_q)
  );
endmodule

// File: tb/tb_lux_i2c_regbank.sv
`timescale 1ns/1ps
module tb_lux_i2c_regbank;
  localparam int Q = 10;
  localparam logic [6:0] CHIP = 7'h39;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, scl_m, sda_m, sda_bus, sda_oe;
  logic [63:0] chan;
  logic [7:0]  ctrl_q, itime_q;
  logic [15:0] thr_lo_q, thr_hi_q;

  assign sda_bus = sda_m & ~sda_oe;

  lux_i2c_regbank dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chan_i(chan), .ctrl_q(ctrl_q), .itime_q(itime_q),
    .thr_lo_q(thr_lo_q), .thr_hi_q(thr_hi_q)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  int nak;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); b = sda_bus; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(nack);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  // wbuf[0] is the register byte; n counts it
  task automatic wr_xfer(input logic [6:0] chip, input int n);
    logic a;
    nak = 0;
    bus_start();
    put_byte({chip, 1'b0}, a); if (a) nak++;
    for (int i = 0; i < n; i++) begin put_byte(wbuf[i], a); if (a) nak++; end
    bus_stop();
  endtask

  task automatic rd_xfer(input bit set_ptr, input logic [7:0] radr, input int n);
    logic a;
    nak = 0;
    if (set_ptr) begin
      bus_start();
      put_byte({CHIP, 1'b0}, a); if (a) nak++;
      put_byte(radr, a); if (a) nak++;
    end
    bus_start();
    put_byte({CHIP, 1'b1}, a); if (a) nak++;
    for (int i = 0; i < n; i++) get_byte(i == n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic wr1(input logic [7:0] r, input logic [7:0] d);
    wbuf[0] = r; wbuf[1] = d; wr_xfer(CHIP, 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R4: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; chan = '0;
    w(8); rst = 1'b0; w(4);

    // R11 reset state
    chk("R11 ctrl", ctrl_q, 0);
    chk("R11 itime", itime_q, 0);
    chk("R11 thr_lo", thr_lo_q, 0);
    chk("R11 thr_hi", thr_hi_q, 0);
    chk("R11 sda_oe", sda_oe, 0);
    rd_xfer(0, 8'h00, 1);
    chk("R11 ptr starts at ctrl", rbuf[0], 8'h00);

    // R1 foreign address: all NACK, nothing written
    wbuf[0] = 8'h00; wbuf[1] = 8'hAA; wr_xfer(7'h38, 2);
    chk("R1 nack count", nak, 3);
    chk("R1 ctrl untouched", ctrl_q, 0);

    // R2 / R4 sweep of burst writes and burst reads
    for (int v = 0; v < 16; v++) begin
      logic [7:0] a, b;
      a = 8'(v * 37 + 5); b = ~a;
      wbuf[0] = 8'h00; wbuf[1] = a; wbuf[2] = b; wr_xfer(CHIP, 3);
      chk("R2 write acks", nak, 0);
      chk("R2 ctrl", ctrl_q, a);
      chk("R2 itime", itime_q, b);
      rd_xfer(1, 8'h00, 2);
      chk("R4 read ctrl", rbuf[0], a);
      chk("R4 read itime", rbuf[1], b);
      chk("R4 released", sda_oe, 0);
    end

    // R3 pointer kept across STOP
    rd_xfer(1, 8'h00, 1);
    rd_xfer(0, 8'h00, 1);
    chk("R3 resume at itime", rbuf[0], itime_q);
    wbuf[0] = 8'h00; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wr_xfer(CHIP, 3);
    rd_xfer(0, 8'h00, 1);
    chk("R3 resume after write at 0x02", rbuf[0], thr_lo_q[7:0]);

    // R6 commit on high byte, 0x00FF -> 0x0100
    wbuf[0] = 8'h02; wbuf[1] = 8'hFF; wbuf[2] = 8'h00; wr_xfer(CHIP, 3);
    chk("R6 thr_lo 00FF", thr_lo_q, 16'h00FF);
    wr1(8'h02, 8'h00);
    chk("R6 low held in shadow", thr_lo_q, 16'h00FF);
    wr1(8'h03, 8'h01);
    chk("R6 committed 0100", thr_lo_q, 16'h0100);
    rd_xfer(1, 8'h02, 2);
    chk("R6 readback lo", rbuf[0], 8'h00);
    chk("R6 readback hi", rbuf[1], 8'h01);

    // R7 shared shadow crossing fields
    wr1(8'h02, 8'h78);
    wr1(8'h05, 8'h56);
    chk("R7 thr_hi gets crossed low", thr_hi_q, 16'h5678);
    chk("R7 thr_lo unchanged", thr_lo_q, 16'h0100);

    // R5 snapshot on low-byte read
    chan[31:16] = 16'hA1B2;
    rd_xfer(1, 8'h22, 1);
    chk("R5 ch1 low", rbuf[0], 8'hB2);
    chan[31:16] = 16'hC3D4;
    rd_xfer(0, 8'h00, 1);
    chk("R5 ch1 high from snapshot", rbuf[0], 8'hA1);
    rd_xfer(1, 8'h22, 2);
    chk("R5 ch1 fresh pair lo", rbuf[0], 8'hD4);
    chk("R5 ch1 fresh pair hi", rbuf[1], 8'hC3);
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 4; k++) chan[k*16 +: 16] = 16'((k + 1) * 16'h1357 + v * 16'h0F1D);
      rd_xfer(1, 8'h20, 8);
      for (int k = 0; k < 4; k++) begin
        logic [15:0] e;
        e = 16'((k + 1) * 16'h1357 + v * 16'h0F1D);
        chk("R5 burst lo", rbuf[2*k], e[7:0]);
        chk("R5 burst hi", rbuf[2*k+1], e[15:8]);
      end
    end

    // R8 constant registers, read-only
    rd_xfer(1, 8'h10, 2);
    chk("R8 id", rbuf[0], 8'hDC);
    chk("R8 rev", rbuf[1], 8'h41);
    wbuf[0] = 8'h10; wbuf[1] = 8'h00; wbuf[2] = 8'h00; wr_xfer(CHIP, 3);
    rd_xfer(1, 8'h10, 2);
    chk("R8 id after write", rbuf[0], 8'hDC);
    chk("R8 rev after write", rbuf[1], 8'h41);
    wr1(8'h20, 8'h99);
    rd_xfer(1, 8'h20, 1);
    chk("R8 channel write ignored", rbuf[0], chan[7:0]);

    // R9 unmapped
    wr1(8'h40, 8'h77);
    chk("R9 unmapped write acked", nak, 0);
    rd_xfer(1, 8'h40, 1);
    chk("R9 unmapped reads zero", rbuf[0], 8'h00);
    rd_xfer(1, 8'h06, 1);
    chk("R9 gap reads zero", rbuf[0], 8'h00);

    // R10 wrap
    wbuf[0] = 8'hFF; wbuf[1] = 8'h11; wbuf[2] = 8'h99; wr_xfer(CHIP, 3);
    chk("R10 wrapped to ctrl", ctrl_q, 8'h99);
    rd_xfer(1, 8'hFF, 2);
    chk("R10 read wrap ff", rbuf[0], 8'h00);
    chk("R10 read wrap 00", rbuf[1], 8'h99);
    chk("R4 released at end", sda_oe, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule